// File: doc/BRIEF.md
# Prescaled 24-bit Down-Counter Timer

This block is a programmable interval timer built around a 24-bit down-counter. The counter steps from one of four clock sources: the system clock through a 5-bit prescaler, the system clock through the prescaler but gated by an external timer input, synchronized rising edges of the external input through the prescaler, or those same edges with the prescaler bypassed. When the counter steps out of zero, it either reloads from a 24-bit preload value or rolls over to all ones. Software chooses this in the control register.

Software reaches the timer through a small byte-wide register window. The window holds one control register, three preload byte lanes, three counter read-back bytes and a status register with a sticky zero-detect flag. The timer output pin can be left to port logic, used as a square wave that toggles on every zero detect, or used as an active-low interrupt request. The interrupt request is either vectored, with an acknowledge input that clears the flag, or autovectored. Reads return data one cycle after `rd_en`.

Top module: `cdt_timer`

## Requirements
- R1: After reset the control register reads 0x00, the counter reads 0x000000, the status flag is 0, and `tout_sel_o`, `tout_oe` and `iack_sel_o` are 0.
- R2: Preload bytes sit at address 1 (bits 23:16), 2 (bits 15:8) and 3 (bits 7:0). A write changes only its own byte, and each byte reads back at its address.
- R3: The control register at address 0 reads back as written, except bit 3, which always reads 0. Field layout: bits 7:5 pin mode, bit 4 zero action, bits 2:1 clock source, bit 0 enable.
- R4: With clock source 11 and enable set, the counter steps once per synchronized rising edge of `tin_i`, with no prescaler.
- R5: With clock source 00 and enable set, the 5-bit prescaler counts down once per clock, starting from 0x1F after reset. The counter steps each time the prescaler passes from 0x00 to 0x1F, which is once every 32 clocks.
- R6: The counter and prescaler hold while enable is 0. With clock source 01 they also hold while `tin_i` is low.
- R7: With control bit 4 at 0, a step taken while the counter is zero loads the preload value.
- R8: With control bit 4 at 1, a step taken while the counter is zero gives 0xFFFFFF.
- R9: The status flag (address 7, bit 0, also `zds_o`) sets when a step leaves the counter at zero. Writing 1 to status bit 0 clears it. Writing 0 has no effect.
- R10: Pin modes 010/011 drive a square wave on `tout_o`. It starts at 1, toggles on every zero detect, and reads 1 while the timer is halted.
- R11: In pin modes 100/110, `tout_oe` is 0. In modes 101/111, the pin drives 0 with `tout_oe` equal to the status flag. Only mode 101 sets `iack_sel_o`, and only in that mode does a high `iack_i` clear the flag.
- R12: Reading the counter high byte (address 4) captures the whole counter. Reads of address 5 and 6 return the captured middle and low bytes even if the counter has moved since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data valid next cycle |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| tin_i | input | 1 | External timer input (asynchronous) |
| iack_i | input | 1 | Interrupt acknowledge |
| tout_o | output | 1 | Timer pin level |
| tout_oe | output | 1 | Timer pin drive enable |
| tout_sel_o | output | 1 | Timer pin owned by the timer rather than the port |
| iack_sel_o | output | 1 | Acknowledge pin owned by the timer |
| zds_o | output | 1 | Zero-detect status flag |

## Verification
A counter that miscounts, or a prescaler that slips, shows up first in the byte-wise counter read-back. It then shows in the moment `zds_o` rises and the square wave flips, at most one prescaler period (32 clocks) or one external edge late. A wrong reload or rollover choice shows on the very next step after zero, as either the preload value or 0xFFFFFF. A stale read snapshot shows only when the counter moves between the high-byte read and the lower-byte reads, so the tests step the counter in that gap.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  // control register bit positions
  localparam int CTL_EN      = 0;
  localparam int CTL_SRC_LO  = 1;
  localparam int CTL_RSV     = 3;
  localparam int CTL_ROLL    = 4;
  localparam int CTL_MODE_LO = 5;

  typedef enum logic [1:0] {
    SRC_SYS        = 2'b00,
    SRC_SYS_GATED  = 2'b01,
    SRC_EXT_PRE    = 2'b10,
    SRC_EXT_DIRECT = 2'b11
  } clk_src_e;

  typedef enum logic [2:0] {
    PIN_PORT_A   = 3'b000,
    PIN_PORT_B   = 3'b001,
    PIN_SQ_A     = 3'b010,
    PIN_SQ_B     = 3'b011,
    PIN_IRQ_OFFV = 3'b100,
    PIN_IRQ_VEC  = 3'b101,
    PIN_IRQ_OFFA = 3'b110,
    PIN_IRQ_AUTO = 3'b111
  } pin_mode_e;
endpackage

// File: rtl/cdt_tick_gen.sv
module cdt_tick_gen
  import cdt_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  clk_src_e         src_i,
  input  logic             tin_i,
  output logic             run_o,
  output logic             step_o,
  output logic             tin_rise_o,
  output logic [PRE_W-1:0] pre_o
);
  logic             s1_q, s2_q, s3_q;
  logic [PRE_W-1:0] pre_q;
  logic             dec_w;

  function automatic logic [PRE_W-1:0] pre_dec(input logic [PRE_W-1:0] v);
    return v - PRE_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= tin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign tin_rise_o = s2_q & ~s3_q;

  always_comb begin
    run_o = en_i;
    dec_w = 1'b0;
    unique case (src_i)
      SRC_SYS:        dec_w = en_i;
      SRC_SYS_GATED:  begin run_o = en_i & s2_q; dec_w = en_i & s2_q; end
      SRC_EXT_PRE:    dec_w = en_i & tin_rise_o;
      SRC_EXT_DIRECT: dec_w = 1'b0;
      default:        dec_w = 1'b0;
    endcase
  end

  assign step_o = (src_i == SRC_EXT_DIRECT) ? (run_o & tin_rise_o)
                                            : (dec_w && pre_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     pre_q <= '1;
    else if (dec_w) pre_q <= pre_dec(pre_q);
  end

  assign pre_o = pre_q;
endmodule

// File: rtl/cdt_down_counter.sv
module cdt_down_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             roll_i,
  input  logic [CNT_W-1:0] preload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zd_evt_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nxt_w;

  function automatic logic [CNT_W-1:0] next_val(input logic [CNT_W-1:0] cur,
                                                input logic [CNT_W-1:0] pl,
                                                input logic             roll);
    if (cur == '0) return roll ? '1 : pl;
    return cur - CNT_W'(1);
  endfunction

  assign nxt_w    = next_val(cnt_q, preload_i, roll_i);
  assign zd_evt_o = step_i && (nxt_w == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (step_i) cnt_q <= nxt_w;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cdt_pin_ctrl.sv
module cdt_pin_ctrl
  import cdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pin_mode_e mode_i,
  input  logic      run_i,
  input  logic      zd_evt_i,
  input  logic      zds_i,
  output logic      sq_o,
  output logic      tout_o,
  output logic      tout_oe,
  output logic      tout_sel_o,
  output logic      iack_sel_o
);
  logic sq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        sq_q <= 1'b1;
    else if (zd_evt_i) sq_q <= ~sq_q;
  end

  assign sq_o = sq_q;

  always_comb begin
    tout_o     = 1'b0;
    tout_oe    = 1'b0;
    tout_sel_o = 1'b1;
    iack_sel_o = 1'b0;
    unique case (mode_i)
      PIN_PORT_A, PIN_PORT_B: tout_sel_o = 1'b0;
      PIN_SQ_A, PIN_SQ_B: begin
        tout_oe = 1'b1;
        tout_o  = run_i ? sq_q : 1'b1;
      end
      PIN_IRQ_OFFV, PIN_IRQ_OFFA: tout_oe = 1'b0;
      PIN_IRQ_VEC: begin
        tout_oe    = zds_i;
        iack_sel_o = 1'b1;
      end
      PIN_IRQ_AUTO: tout_oe = zds_i;
      default: tout_sel_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PRE_W  = 5,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              tin_i,
  input  logic              iack_i,
  output logic              tout_o,
  output logic              tout_oe,
  output logic              tout_sel_o,
  output logic              iack_sel_o,
  output logic              zds_o
);
  localparam int NBYTES    = CNT_W / DATA_W;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_PRE  = 1;
  localparam int ADDR_CNT  = ADDR_PRE + NBYTES;
  localparam int ADDR_STAT = ADDR_CNT + NBYTES;

  logic [DATA_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  preload_q;
  logic [CNT_W-1:0]  snap_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_next;
  logic              zds_q;

  // named internal events
  logic             run_w, step_w, tin_rise_w, zd_evt_w, sq_w;
  logic [PRE_W-1:0] pre_w;
  logic [CNT_W-1:0] cnt_w;
  clk_src_e         src_w;
  pin_mode_e        mode_w;
  logic             hi_read_w, stat_clr_w;

  assign src_w  = clk_src_e'(ctrl_q[CTL_SRC_LO +: 2]);
  assign mode_w = pin_mode_e'(ctrl_q[CTL_MODE_LO +: 3]);

  cdt_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en_i(ctrl_q[CTL_EN]), .src_i(src_w),
    .tin_i(tin_i), .run_o(run_w), .step_o(step_w), .tin_rise_o(tin_rise_w),
    .pre_o(pre_w)
  );

  cdt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step_i(step_w), .roll_i(ctrl_q[CTL_ROLL]),
    .preload_i(preload_q), .cnt_o(cnt_w), .zd_evt_o(zd_evt_w)
  );

  cdt_pin_ctrl u_pin (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_w), .run_i(run_w),
    .zd_evt_i(zd_evt_w), .zds_i(zds_q), .sq_o(sq_w), .tout_o(tout_o),
    .tout_oe(tout_oe), .tout_sel_o(tout_sel_o), .iack_sel_o(iack_sel_o)
  );

  // control register, bit 3 forced to zero
  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (wr_en && addr == ADDR_W'(ADDR_CTRL))
      ctrl_q <= wdata & ~(DATA_W'(1) << CTL_RSV);
  end

  // preload byte lanes, highest byte at the lowest address
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preload_q <= '0;
    end else begin
      for (int b = 0; b < NBYTES; b++) begin
        if (wr_en && addr == ADDR_W'(ADDR_PRE + NBYTES - 1 - b))
          preload_q[b*DATA_W +: DATA_W] <= wdata;
      end
    end
  end

  // status flag: a zero detect wins over a clear in the same cycle
  assign stat_clr_w = (wr_en && addr == ADDR_W'(ADDR_STAT) && wdata[0]) ||
                      (iack_i && iack_sel_o);

  always_ff @(posedge clk) begin
    if (!rst_n)          zds_q <= 1'b0;
    else if (zd_evt_w)   zds_q <= 1'b1;
    else if (stat_clr_w) zds_q <= 1'b0;
  end

  assign zds_o = zds_q;

  // read path
  assign hi_read_w = rd_en && addr == ADDR_W'(ADDR_CNT);

  always_comb begin
    rd_next = '0;
    if (addr == ADDR_W'(ADDR_CTRL)) rd_next = ctrl_q;
    if (addr == ADDR_W'(ADDR_STAT)) rd_next[0] = zds_q;
    for (int b = 0; b < NBYTES; b++) begin
      if (addr == ADDR_W'(ADDR_PRE + NBYTES - 1 - b))
        rd_next = preload_q[b*DATA_W +: DATA_W];
      if (addr == ADDR_W'(ADDR_CNT + NBYTES - 1 - b))
        rd_next = (b == NBYTES - 1) ? cnt_w[b*DATA_W +: DATA_W]
                                    : snap_q[b*DATA_W +: DATA_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      snap_q  <= '0;
    end else begin
      if (rd_en)     rdata_q <= rd_next;
      if (hi_read_w) snap_q  <= cnt_w;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk #(
  parameter int CNT_W  = 24,
  parameter int PRE_W  = 5,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic              rdata_b3,
  input logic [2:0]        mode,
  input logic              roll,
  input logic [1:0]        src,
  input logic              run,
  input logic              step,
  input logic              tin_rise,
  input logic              zd_evt,
  input logic [CNT_W-1:0]  cnt,
  input logic [PRE_W-1:0]  pre,
  input logic [CNT_W-1:0]  preload,
  input logic              zds,
  input logic              sq,
  input logic              tout_oe,
  input logic              iack_sel
);
  a_r3_rsv_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == '0) |=> !rdata_b3);

  a_r4_direct_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    (step && src == 2'b11) |-> tin_rise);

  a_r6_hold_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(cnt) && $stable(pre)));

  a_r7_reload_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt == '0 && !roll) |=> cnt == $past(preload));

  a_r8_rollover_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step && cnt == '0 && roll) |=> cnt == '1);

  a_r9_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    zd_evt |=> zds);

  a_r10_square_flips: assert property (@(posedge clk) disable iff (!rst_n)
    zd_evt |=> sq != $past(sq));

  a_r11_disabled_irq_tristate: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b100 || mode == 3'b110) |-> !tout_oe);

  a_r11_ack_pin_vectored_only: assert property (@(posedge clk) disable iff (!rst_n)
    iack_sel |-> mode == 3'b101);
endmodule

bind cdt_timer cdt_timer_chk #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata_b3(rdata[3]),
  .mode(ctrl_q[7:5]), .roll(ctrl_q[4]), .src(ctrl_q[2:1]), .run(run_w),
  .step(step_w), .tin_rise(tin_rise_w), .zd_evt(zd_evt_w), .cnt(cnt_w),
  .pre(pre_w), .preload(preload_q), .zds(zds_q), .sq(sq_w),
  .tout_oe(tout_oe), .iack_sel(iack_sel_o)
);

// File: tb/cdt_timer_test.sv
module cdt_timer_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tin_i = 1'b0, iack_i = 1'b0;
  logic       tout_o, tout_oe, tout_sel_o, iack_sel_o, zds_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cdt_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tin_i(tin_i), .iack_i(iack_i),
    .tout_o(tout_o), .tout_oe(tout_oe), .tout_sel_o(tout_sel_o),
    .iack_sel_o(iack_sel_o), .zds_o(zds_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tin_i = 1'b0; iack_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rd_cnt(output logic [23:0] v);
    logic [7:0] h, m, l;
    rd(3'd4, h); rd(3'd5, m); rd(3'd6, l);
    v = {h, m, l};
  endtask

  task automatic tin_pulse();
    @(negedge clk); tin_i = 1'b1;
    repeat (4) @(negedge clk);
    tin_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic iack_pulse();
    @(negedge clk); iack_i = 1'b1;
    @(negedge clk); iack_i = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [7:0] d; logic [23:0] c;
    do_reset();
    rd(3'd0, d);  chk("R1 ctrl", d, 8'h00);
    rd_cnt(c);    chk("R1 count", c, 24'h0);
    chk("R1 zds", zds_o, 1'b0);
    chk("R1 pins", {tout_sel_o, tout_oe, iack_sel_o}, 3'b000);
  endtask

  task automatic t_preload_lanes();
    logic [7:0] h, m, l;
    do_reset();
    wr(3'd1, 8'hAA); wr(3'd2, 8'hBB); wr(3'd3, 8'hCC);
    wr(3'd2, 8'h11);
    rd(3'd1, h); rd(3'd2, m); rd(3'd3, l);
    chk("R2 preload lanes", {h, m, l}, 24'hAA11CC);
  endtask

  task automatic t_ctrl_readback();
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'hFF); rd(3'd0, d); chk("R3 bit3 reads zero", d, 8'hF7);
    wr(3'd0, 8'h52); rd(3'd0, d); chk("R3 readback", d, 8'h52);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_direct_and_reload();
    logic [23:0] c;
    do_reset();
    wr(3'd3, 8'h05);
    wr(3'd0, 8'h07);              // src 11, reload, enabled
    repeat (3) tin_pulse();       // 0 -> 5 -> 4 -> 3
    rd_cnt(c); chk("R4 direct edges", c, 24'h3);
    chk("R9 flag still clear", zds_o, 1'b0);
    repeat (3) tin_pulse();       // 2, 1, 0
    rd_cnt(c); chk("R4 reached zero", c, 24'h0);
    chk("R9 flag set at zero", zds_o, 1'b1);
    tin_pulse();
    rd_cnt(c); chk("R7 reload from preload", c, 24'h5);
    wr(3'd7, 8'h00); chk("R9 write 0 no effect", zds_o, 1'b1);
    wr(3'd7, 8'h01); chk("R9 write 1 clears", zds_o, 1'b0);
  endtask

  task automatic t_rollover();
    logic [23:0] c;
    do_reset();
    wr(3'd3, 8'h09);
    wr(3'd0, 8'h17);              // rollover, src 11, enabled
    tin_pulse();
    rd_cnt(c); chk("R8 rollover", c, 24'hFFFFFF);
    chk("R8 no flag on rollover", zds_o, 1'b0);
  endtask

  task automatic t_prescaled();
    logic [23:0] c;
    do_reset();
    wr(3'd3, 8'd100);
    wr(3'd0, 8'h01);              // src 00, enabled
    repeat (319) @(negedge clk);
    wr(3'd0, 8'h00);              // 321 prescaler decrements -> 10 steps
    rd_cnt(c); chk("R5 prescaled count", c, 24'd91);
    repeat (100) @(negedge clk);
    rd_cnt(c); chk("R6 hold when disabled", c, 24'd91);
  endtask

  task automatic t_gated();
    logic [23:0] c1, c2;
    do_reset();
    wr(3'd3, 8'h10);
    wr(3'd0, 8'h03);              // src 01, enabled
    repeat (100) @(negedge clk);
    rd_cnt(c1); chk("R6 gated off by low tin", c1, 24'h0);
    tin_i = 1'b1;
    repeat (200) @(negedge clk);
    tin_i = 1'b0;
    repeat (5) @(negedge clk);
    rd_cnt(c1); chk("R6 runs with tin high", (c1 != 24'h0), 1'b1);
    repeat (100) @(negedge clk);
    rd_cnt(c2); chk("R6 holds after tin low", c2, c1);
  endtask

  task automatic t_square();
    do_reset();
    wr(3'd3, 8'h02);
    wr(3'd0, 8'h46);              // square mode, src 11, halted
    chk("R10 halted high", {tout_sel_o, tout_oe, tout_o}, 3'b111);
    wr(3'd0, 8'h47);
    chk("R10 start level", tout_o, 1'b1);
    repeat (3) tin_pulse();       // 2,1,0
    chk("R10 first toggle", tout_o, 1'b0);
    repeat (3) tin_pulse();       // 2,1,0
    chk("R10 second toggle", tout_o, 1'b1);
    repeat (3) tin_pulse();
    chk("R10 third toggle", tout_o, 1'b0);
    wr(3'd0, 8'h46);
    chk("R10 high when halted", tout_o, 1'b1);
  endtask

  task automatic t_irq();
    do_reset();
    wr(3'd3, 8'h01);
    wr(3'd0, 8'h87);              // irq disabled (100)
    repeat (2) tin_pulse();       // 0->1->0
    chk("R11 flag set", zds_o, 1'b1);
    chk("R11 mode100 tristate", {tout_sel_o, tout_oe, iack_sel_o}, 3'b100);
    wr(3'd0, 8'hC7);
    chk("R11 mode110 tristate", tout_oe, 1'b0);
    wr(3'd0, 8'hA7);              // vectored
    chk("R11 mode101 drive low", {tout_oe, tout_o, iack_sel_o}, 3'b101);
    iack_pulse();
    chk("R11 ack clears in 101", zds_o, 1'b0);
    chk("R11 released after ack", tout_oe, 1'b0);
    repeat (2) tin_pulse();
    wr(3'd0, 8'hE7);              // autovectored
    chk("R11 mode111 drive low", {tout_oe, tout_o, iack_sel_o}, 3'b100);
    iack_pulse();
    chk("R11 ack ignored in 111", zds_o, 1'b1);
  endtask

  task automatic t_coherent();
    logic [7:0] h, m, l;
    do_reset();
    wr(3'd1, 8'h01); wr(3'd2, 8'h23); wr(3'd3, 8'h45);
    wr(3'd0, 8'h07);
    tin_pulse();                  // load 0x012345
    rd(3'd4, h);
    repeat (2) tin_pulse();       // counter now 0x012343
    rd(3'd5, m); rd(3'd6, l);
    chk("R12 snapshot", {h, m, l}, 24'h012345);
    rd(3'd4, h); rd(3'd5, m); rd(3'd6, l);
    chk("R12 fresh snapshot", {h, m, l}, 24'h012343);
  endtask

  initial begin
    t_reset_state();
    t_preload_lanes();
    t_ctrl_readback();
    t_direct_and_reload();
    t_rollover();
    t_prescaled();
    t_gated();
    t_square();
    t_irq();
    t_coherent();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule